// File: doc/BRIEF.md
# Tiny Accumulator Instruction Processor

This block is a very small processor core built around three working registers: an accumulator, a general register and a condition register that also serves as a loop counter. A program counter sits next to them. It takes one instruction per clock on a 4-bit opcode input and carries it out in that same clock edge. Data comes in on an input bus, and results leave through an output bus that has a one-cycle valid strobe. The current program counter is always visible on its own output, so external logic can fetch the next opcode.

The twelve instructions do the following. They load the accumulator or the general register from the input bus. They copy the accumulator into the general register. They move the general register into the condition register and back again. They add, OR or AND the general register into the accumulator. They decrement the general register. They put either the accumulator or the general register on the output bus. The last instruction is a conditional jump: it takes its target address straight from the input bus, and it is taken only when the condition register holds zero. A loop therefore counts down in the general register, parks the count in the condition register and then tests it.

Top module: `tiny_acc_cpu`

## Requirements
- R1: When the synchronous active-high reset is sampled high, the accumulator, general register, condition register, program counter, output bus and output strobe all become zero.
- R2: Opcode 1 loads the accumulator from the input bus. Opcode 5 loads the general register from the input bus.
- R3: Opcode 2 copies the accumulator into the general register. Opcode 10 copies the general register into the condition register. Opcode 11 copies the condition register into the general register.
- R4: Opcode 3 puts the general register on the output bus. Opcode 4 puts the accumulator on the output bus. In both cases the output strobe is high in the cycle that follows the edge on which the opcode was sampled.
- R5: After any opcode other than 3 or 4, the output strobe is low and the output bus keeps its previous value.
- R6: Opcode 6 sets the accumulator to the accumulator plus the general register, modulo 2^DW. No carry is kept.
- R7: Opcode 7 sets the accumulator to the bitwise OR of the accumulator and the general register. Opcode 8 sets it to their bitwise AND.
- R8: Opcode 9 sets the general register to itself minus one, modulo 2^DW, so 0 becomes all ones.
- R9: When opcode 12 is sampled and the condition register is zero, the program counter loads the input bus value. When the condition register is nonzero, the program counter advances by one.
- R10: Every opcode other than 12 advances the program counter by one, modulo 2^AW, so the maximum value wraps to 0.
- R11: Opcodes 0, 13, 14 and 15 change none of the accumulator, general register, condition register or output bus. They only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Opcode executed on this clock edge |
| in_data | input | DW | Input data bus, also the jump target |
| out_data | output | DW | Output data bus, held between output instructions |
| out_valid | output | 1 | High for one cycle after each output instruction |
| pc_o | output | AW | Program counter |

## Verification
Every result is registered. An opcode and its input data, sampled on one rising edge, show their effect on the program counter, the output bus and the strobe right after that same edge. Nothing appears a cycle later. The bench applies stimulus on falling edges and compares all three outputs on the next falling edge against a reference model that it advanced while applying that stimulus. Register contents that are not on a port are checked indirectly: opcodes 3, 4 and 11 route them to the output bus, and the jump decision reveals whether the condition register is zero.

// File: rtl/tac_pkg.sv
package tac_pkg;

   localparam int OPW = 4;

   typedef enum logic [OPW-1:0] {
      OP_NOP0   = 4'd0,
      OP_LDA_IN = 4'd1,
      OP_MOV_RA = 4'd2,
      OP_OUT_R  = 4'd3,
      OP_OUT_A  = 4'd4,
      OP_LDR_IN = 4'd5,
      OP_ADD    = 4'd6,
      OP_OR     = 4'd7,
      OP_AND    = 4'd8,
      OP_DEC    = 4'd9,
      OP_MOV_CR = 4'd10,
      OP_MOV_RC = 4'd11,
      OP_JZ     = 4'd12
   } tac_op_e;

   typedef enum logic [1:0] {
      ASEL_IN,
      ASEL_ADD,
      ASEL_OR,
      ASEL_AND
   } tac_asel_e;

   typedef enum logic [1:0] {
      RSEL_IN,
      RSEL_A,
      RSEL_C,
      RSEL_DEC
   } tac_rsel_e;

   typedef struct packed {
      logic      a_we;
      tac_asel_e a_sel;
      logic      r_we;
      tac_rsel_e r_sel;
      logic      c_we;
      logic      out_en;
      logic      out_sel_a;
      logic      jump;
   } tac_ctl_t;

endpackage

// File: rtl/tac_decode.sv
module tac_decode
   import tac_pkg::*;
(
   input  logic [OPW-1:0] op_i,
   output tac_ctl_t       ctl_o
);

   always_comb begin
      ctl_o = '{a_we: 1'b0, a_sel: ASEL_IN, r_we: 1'b0, r_sel: RSEL_IN,
                c_we: 1'b0, out_en: 1'b0, out_sel_a: 1'b0, jump: 1'b0};
      case (op_i)
         OP_LDA_IN: begin ctl_o.a_we = 1'b1; ctl_o.a_sel = ASEL_IN;  end
         OP_ADD:    begin ctl_o.a_we = 1'b1; ctl_o.a_sel = ASEL_ADD; end
         OP_OR:     begin ctl_o.a_we = 1'b1; ctl_o.a_sel = ASEL_OR;  end
         OP_AND:    begin ctl_o.a_we = 1'b1; ctl_o.a_sel = ASEL_AND; end
         OP_LDR_IN: begin ctl_o.r_we = 1'b1; ctl_o.r_sel = RSEL_IN;  end
         OP_MOV_RA: begin ctl_o.r_we = 1'b1; ctl_o.r_sel = RSEL_A;   end
         OP_MOV_RC: begin ctl_o.r_we = 1'b1; ctl_o.r_sel = RSEL_C;   end
         OP_DEC:    begin ctl_o.r_we = 1'b1; ctl_o.r_sel = RSEL_DEC; end
         OP_MOV_CR: ctl_o.c_we = 1'b1;
         OP_OUT_R:  ctl_o.out_en = 1'b1;
         OP_OUT_A:  begin ctl_o.out_en = 1'b1; ctl_o.out_sel_a = 1'b1; end
         OP_JZ:     ctl_o.jump = 1'b1;
         default:   ;
      endcase
   end

endmodule

// File: rtl/tac_datapath.sv
module tac_datapath
   import tac_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] r_i,
   input  logic [DW-1:0] c_i,
   input  logic [DW-1:0] in_i,
   input  tac_asel_e     a_sel_i,
   input  tac_rsel_e     r_sel_i,
   output logic [DW-1:0] a_nx_o,
   output logic [DW-1:0] r_nx_o
);

   logic [DW-1:0] sum_w;
   logic [DW-1:0] or_w;
   logic [DW-1:0] and_w;
   logic [DW-1:0] dec_w;

   // per-bit logic slices
   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign or_w[b]  = a_i[b] | r_i[b];
      assign and_w[b] = a_i[b] & r_i[b];
   end

   assign sum_w = a_i + r_i;
   assign dec_w = r_i - {{(DW-1){1'b0}}, 1'b1};

   always_comb begin
      case (a_sel_i)
         ASEL_ADD: a_nx_o = sum_w;
         ASEL_OR:  a_nx_o = or_w;
         ASEL_AND: a_nx_o = and_w;
         default:  a_nx_o = in_i;
      endcase
   end

   always_comb begin
      case (r_sel_i)
         RSEL_A:   r_nx_o = a_i;
         RSEL_C:   r_nx_o = c_i;
         RSEL_DEC: r_nx_o = dec_w;
         default:  r_nx_o = in_i;
      endcase
   end

endmodule

// File: rtl/tac_pc.sv
module tac_pc #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          jump_i,
   input  logic          c_zero_i,
   input  logic [DW-1:0] in_i,
   output logic [AW-1:0] pc_o
);

   logic [AW-1:0] target_w;

   if (AW <= DW) begin : g_trunc
      assign target_w = in_i[AW-1:0];
   end else begin : g_zext
      assign target_w = {{(AW-DW){1'b0}}, in_i};
   end

   always_ff @(posedge clk) begin
      if (rst)
         pc_o <= '0;
      else if (jump_i && c_zero_i)
         pc_o <= target_w;
      else
         pc_o <= pc_o + {{(AW-1){1'b0}}, 1'b1};
   end

endmodule

// File: rtl/tiny_acc_cpu.sv
module tiny_acc_cpu
   import tac_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [3:0]    op_i,
   input  logic [DW-1:0] in_data,
   output logic [DW-1:0] out_data,
   output logic          out_valid,
   output logic [AW-1:0] pc_o
);

   if (DW < 2 || DW > 64) begin : g_bad_dw
      $error("tiny_acc_cpu: DW out of range");
   end
   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("tiny_acc_cpu: AW out of range");
   end
   if (OPW != 4) begin : g_bad_opw
      $error("tiny_acc_cpu: opcode width must be 4");
   end

   tac_ctl_t      ctl;
   logic [DW-1:0] a_q, r_q, c_q;
   logic [DW-1:0] a_nx, r_nx;
   logic          c_zero;

   tac_decode u_dec (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   tac_datapath #(.DW(DW)) u_dp (
      .a_i     (a_q),
      .r_i     (r_q),
      .c_i     (c_q),
      .in_i    (in_data),
      .a_sel_i (ctl.a_sel),
      .r_sel_i (ctl.r_sel),
      .a_nx_o  (a_nx),
      .r_nx_o  (r_nx)
   );

   assign c_zero = (c_q == '0);

   tac_pc #(.AW(AW), .DW(DW)) u_pc (
      .clk      (clk),
      .rst      (rst),
      .jump_i   (ctl.jump),
      .c_zero_i (c_zero),
      .in_i     (in_data),
      .pc_o     (pc_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         r_q <= '0;
         c_q <= '0;
      end else begin
         if (ctl.a_we) a_q <= a_nx;
         if (ctl.r_we) r_q <= r_nx;
         if (ctl.c_we) c_q <= r_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= ctl.out_en;
         if (ctl.out_en)
            out_data <= ctl.out_sel_a ? a_q : r_q;
      end
   end

endmodule

// File: rtl/tac_chk.sv
module tac_chk #(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic [3:0]    op_i,
   input logic [DW-1:0] in_data,
   input logic [DW-1:0] out_data,
   input logic          out_valid,
   input logic [AW-1:0] pc_o,
   input logic [DW-1:0] r_q,
   input logic [DW-1:0] c_q
);

   logic [AW-1:0] in_as_pc;
   if (AW <= DW) begin : g_t
      assign in_as_pc = in_data[AW-1:0];
   end else begin : g_z
      assign in_as_pc = {{(AW-DW){1'b0}}, in_data};
   end

   // R10
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i != 4'd12) |=> ((pc_o - $past(pc_o)) == AW'(1)));

   // R9
   jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 4'd12 && c_q == '0) |=> (pc_o == $past(in_as_pc)));

   // R9
   jump_skip_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 4'd12 && c_q != '0) |=> ((pc_o - $past(pc_o)) == AW'(1)));

   // R4
   strobe_on_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 4'd3 || op_i == 4'd4) |=> out_valid);

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(op_i == 4'd3 || op_i == 4'd4) |=> (!out_valid && $stable(out_data)));

   // R8
   dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 4'd9) |=> ((($past(r_q) - r_q)) == DW'(1)));

   // R3
   c_load_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 4'd10) |=> (c_q == $past(r_q)));

endmodule

bind tiny_acc_cpu tac_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .op_i      (op_i),
   .in_data   (in_data),
   .out_data  (out_data),
   .out_valid (out_valid),
   .pc_o      (pc_o),
   .r_q       (r_q),
   .c_q       (c_q)
);

// File: tb/tb_tiny_acc_cpu.sv
module tb_tiny_acc_cpu;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [3:0]    op_i = 4'd0;
   logic [DW-1:0] in_data = '0;
   logic [DW-1:0] out_data;
   logic          out_valid;
   logic [AW-1:0] pc_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DW-1:0] ma = '0, mr = '0, mc = '0, mout = '0;
   logic [AW-1:0] mpc = '0;
   logic          mval = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tiny_acc_cpu #(.DW(DW), .AW(AW)) dut (
      .clk       (clk),
      .rst       (rst),
      .op_i      (op_i),
      .in_data   (in_data),
      .out_data  (out_data),
      .out_valid (out_valid),
      .pc_o      (pc_o)
   );

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd1, 4'd5:         return "R2";
         4'd2, 4'd10, 4'd11: return "R3";
         4'd3, 4'd4:         return "R4";
         4'd6:               return "R6";
         4'd7, 4'd8:         return "R7";
         4'd9:               return "R8";
         4'd12:              return "R9";
         default:            return "R11";
      endcase
   endfunction

   // reference model: state after the next edge
   task automatic model_step(input logic [3:0] op, input logic [DW-1:0] din);
      logic [DW-1:0] a0, r0, c0;
      a0 = ma; r0 = mr; c0 = mc;
      mval = 1'b0;
      mpc  = mpc + 1'b1;
      case (op)
         4'd1:  ma = din;
         4'd2:  mr = a0;
         4'd3:  begin mout = r0; mval = 1'b1; end
         4'd4:  begin mout = a0; mval = 1'b1; end
         4'd5:  mr = din;
         4'd6:  ma = a0 + r0;
         4'd7:  ma = a0 | r0;
         4'd8:  ma = a0 & r0;
         4'd9:  mr = r0 - 1'b1;
         4'd10: mc = r0;
         4'd11: mr = c0;
         4'd12: if (c0 == '0) mpc = din[AW-1:0];
         default: ;
      endcase
   endtask

   task automatic check(input string tag);
      n_vec++;
      if (out_valid !== mval || out_data !== mout || pc_o !== mpc) begin
         n_bad++;
         $display("FAIL %s: got valid=%0b data=%0h pc=%0h, expected valid=%0b data=%0h pc=%0h",
                  tag, out_valid, out_data, pc_o, mval, mout, mpc);
      end
   endtask

   // apply on a falling edge, check on the next falling edge
   task automatic step(input logic [3:0] op, input logic [DW-1:0] din, input string tag);
      op_i = op;
      in_data = din;
      model_step(op, din);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst = 1'b0;

      // directed corner cases
      step(4'd1, 8'd200, "R2 load A");
      step(4'd2, 8'h00,  "R3 R<=A");
      step(4'd6, 8'h00,  "R6 add wrap");
      step(4'd4, 8'h00,  "R4/R6 out A=144");
      step(4'd3, 8'h00,  "R4 out R back-to-back");
      step(4'd0, 8'h5A,  "R5/R11 nop holds");
      step(4'd5, 8'h00,  "R2 load R=0");
      step(4'd9, 8'h00,  "R8 dec 0->FF");
      step(4'd3, 8'h00,  "R8 out R=FF");
      step(4'd1, 8'hF0,  "R2 load A");
      step(4'd7, 8'h00,  "R7 OR");
      step(4'd5, 8'h3C,  "R2 load R");
      step(4'd8, 8'h00,  "R7 AND");
      step(4'd4, 8'h00,  "R7 out A");
      step(4'd10, 8'h00, "R3 C<=R nonzero");
      step(4'd12, 8'h40, "R9 jump not taken");
      step(4'd5, 8'h00,  "R2 load R=0");
      step(4'd10, 8'h00, "R3 C<=R zero");
      step(4'd12, 8'hFF, "R9 jump taken");
      step(4'd13, 8'h00, "R10 pc wrap / R11");
      step(4'd5, 8'h77,  "R2 load R");
      step(4'd11, 8'h00, "R3 R<=C");
      step(4'd3, 8'h00,  "R3 out R=C");
      step(4'd14, 8'hAA, "R11 nop 14");
      step(4'd15, 8'hAA, "R11 nop 15");

      // mid-run reset
      rst = 1'b1;
      ma = '0; mr = '0; mc = '0; mpc = '0; mout = '0; mval = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run");
      rst = 1'b0;

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [3:0]    op;
         logic [DW-1:0] d;
         op = 4'($urandom_range(0, 15));
         d  = ($urandom_range(0, 3) == 0) ? '0 : DW'($urandom);
         step(op, d, req_of(op));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no completion, expected run to end");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule